// File: doc/BRIEF.md
# Privileged Status Register Unit

This block keeps a processor's 16-bit status word together with two banked stack pointers. The low byte carries the five condition flags. The execution datapath updates them, and a status write in either mode may replace them. The high byte carries the trace enable, the supervisor bit and a 3-bit interrupt priority mask. That byte changes only through a full-word write made in supervisor mode, or through exception entry. A full-word write made in user mode is refused and reported on a one-cycle violation strobe.

The mode controller is a two-state machine, and its state is the supervisor bit. `MD_SUPER` is entered on reset and on exception entry, which is the `T_EXC_ENTRY` transition. It is left through `T_DROP_PRIV`, which is a full-word write in supervisor mode that clears bit 13. Every other input keeps the current state, which is `T_HOLD`. In `MD_USER` a full-word write without an exception takes `T_PRIV_FAULT`: the state holds and the violation strobe is raised. The supervisor bit also picks which stack-pointer copy drives the stack-pointer output and which copy receives stack-pointer writes. A combinational gate compares an incoming interrupt level with the mask.

Top module: `psr_unit`

## Requirements
- R1: After reset the status word reads 0x2700. The unit is in supervisor mode with mask 7, trace off, all flags clear and the violation strobe low. Both stack-pointer copies read zero.
- R2: The flag update strobe loads `alu_flags` into status bits 4:0 on the next clock. The bit order is carry at bit 0, overflow at bit 1, zero at bit 2, negative at bit 3 and extend at bit 4. Bits 7:5 always read zero.
- R3: A low-byte write (`sr_wr_full`=0) is accepted in both modes and loads bits 4:0 from the write data. It leaves the high byte unchanged and wins over a flag update in the same cycle.
- R4: A full-word write (`sr_wr_full`=1) made in supervisor mode loads bit 15 (trace), bit 13 (supervisor), bits 10:8 (mask) and bits 4:0 (flags). Bits 14, 12, 11 and 7:5 read zero.
- R5: A full-word write made in user mode leaves the whole status word unchanged. `priv_viol` is then high for the single following cycle.
- R6: Exception entry copies the pre-edge status word to `saved_sr`, sets bit 13 and clears bit 15. It keeps the mask and flags, overrides any status write or flag update in the same cycle, and never raises `priv_viol`.
- R7: `sp_out` shows the supervisor copy whenever bit 13 is set and the user copy whenever it is clear. It switches in the same cycle that bit 13 changes.
- R8: A stack-pointer write goes to the copy selected by bit 13 before the clock edge. The other copy keeps its value.
- R9: `irq_fwd` is high exactly when `irq_level` is above the mask or equals 7. Level 0 is never forwarded.
- R10: `supv_mode`, `trace_en` and `int_mask` always equal bit 13, bit 15 and bits 10:8 of `sr_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alu_flag_we | input | 1 | Flag update strobe from the datapath |
| alu_flags | input | 5 | New flags {X,N,Z,V,C} |
| sr_wr_en | input | 1 | Status write request |
| sr_wr_full | input | 1 | 1: full-word write, 0: low byte only |
| sr_wr_data | input | 16 | Status write data |
| exc_req | input | 1 | Exception entry request |
| sp_wr_en | input | 1 | Stack-pointer write strobe |
| sp_wr_data | input | SP_W | Stack-pointer write data |
| irq_level | input | 3 | Pending interrupt level |
| sr_out | output | 16 | Current status word |
| saved_sr | output | 16 | Status word captured at the last exception entry |
| supv_mode | output | 1 | Supervisor mode active |
| trace_en | output | 1 | Single-step trace enable |
| int_mask | output | 3 | Interrupt priority mask |
| priv_viol | output | 1 | One-cycle privilege-violation strobe |
| sp_out | output | SP_W | Active stack pointer |
| irq_fwd | output | 1 | Interrupt request passes the mask |

## Verification
Every registered result (`sr_out` and its decoded fields, `saved_sr`, `priv_viol`, `sp_out`) is due one clock edge after the inputs that cause it. The only exception is `sp_out`'s bank switch, which appears in that same cycle together with bit 13. The bench drives each stimulus well before a rising edge and reads the results 2 ns after that edge. Each result is therefore checked exactly once, in the first cycle it is due and before the next stimulus arrives. `irq_fwd` has no register in its path, so it is compared after a short settle delay within the same cycle its level is driven. The violation strobe is also checked in the cycle after its pulse, to confirm the pulse lasts one cycle.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int SR_W     = 16;
    localparam int FLAG_W   = 5;
    localparam int MASK_W   = 3;
    localparam int BIT_TR   = 15;
    localparam int BIT_SV   = 13;
    localparam int MASK_LO  = 8;
    localparam int MASK_HI  = MASK_LO + MASK_W - 1;
    localparam logic [SR_W-1:0] SR_RESET = 16'h2700;

    typedef enum logic {
        MD_USER  = 1'b0,
        MD_SUPER = 1'b1
    } mode_e;

    function automatic logic [SR_W-1:0] pack_sr(
        input logic              tr,
        input logic              sv,
        input logic [MASK_W-1:0] msk,
        input logic [FLAG_W-1:0] flg
    );
        logic [SR_W-1:0] w;
        w                  = '0;
        w[BIT_TR]          = tr;
        w[BIT_SV]          = sv;
        w[MASK_HI:MASK_LO] = msk;
        w[FLAG_W-1:0]      = flg;
        return w;
    endfunction

endpackage

// File: rtl/psr_mode_fsm.sv
module psr_mode_fsm
    import psr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_req,
    input  logic              wr_en,
    input  logic              wr_full,
    input  logic              wr_trace,
    input  logic              wr_super,
    input  logic [MASK_W-1:0] wr_mask,
    output logic              supv,
    output logic              trace,
    output logic [MASK_W-1:0] mask,
    output logic              viol
);

    mode_e             state_q, state_d;
    logic              trace_q, trace_d;
    logic [MASK_W-1:0] mask_q,  mask_d;
    logic              viol_q,  viol_d;
    logic              full_req;

    assign full_req = wr_en && wr_full;

    // next-state and next-field logic
    always_comb begin
        state_d = state_q;
        trace_d = trace_q;
        mask_d  = mask_q;
        viol_d  = 1'b0;
        unique case (state_q)
            MD_SUPER: begin
                if (exc_req) begin
                    state_d = MD_SUPER;      // T_EXC_ENTRY
                    trace_d = 1'b0;
                end else if (full_req) begin
                    trace_d = wr_trace;
                    mask_d  = wr_mask;
                    state_d = wr_super ? MD_SUPER : MD_USER; // T_HOLD / T_DROP_PRIV
                end
            end
            MD_USER: begin
                if (exc_req) begin
                    state_d = MD_SUPER;      // T_EXC_ENTRY
                    trace_d = 1'b0;
                end else if (full_req) begin
                    viol_d  = 1'b1;          // T_PRIV_FAULT
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MD_SUPER;
            trace_q <= 1'b0;
            mask_q  <= '1;
            viol_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            trace_q <= trace_d;
            mask_q  <= mask_d;
            viol_q  <= viol_d;
        end
    end

    // outputs
    always_comb begin
        supv  = (state_q == MD_SUPER);
        trace = trace_q;
        mask  = mask_q;
        viol  = viol_q;
    end

    p_user_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MD_USER && full_req && !exc_req)
            |=> (viol_q && state_q == MD_USER && $stable(mask_q) && $stable(trace_q)));

    p_exc_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> (state_q == MD_SUPER && !trace_q && !viol_q && $stable(mask_q)));

    p_user_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MD_USER && !exc_req) |=> (state_q == MD_USER));

endmodule

// File: rtl/psr_flags.sv
module psr_flags
    import psr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_req,
    input  logic              supv,
    input  logic              wr_en,
    input  logic              wr_full,
    input  logic [FLAG_W-1:0] wr_flags,
    input  logic              alu_we,
    input  logic [FLAG_W-1:0] alu_flags,
    output logic [FLAG_W-1:0] flags
);

    logic              wr_ok;
    logic [FLAG_W-1:0] flags_q;

    assign wr_ok = wr_en && (!wr_full || supv);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (exc_req) begin
            flags_q <= flags_q;
        end else if (wr_ok) begin
            flags_q <= wr_flags;
        end else if (alu_we) begin
            flags_q <= alu_flags;
        end
    end

    assign flags = flags_q;

    p_alu_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_we && !wr_en && !exc_req) |=> (flags_q == $past(alu_flags)));

    p_low_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_full && !exc_req) |=> (flags_q == $past(wr_flags)));

endmodule

// File: rtl/psr_sp_bank.sv
module psr_sp_bank #(
    parameter int SP_W = 32,
    parameter logic [SP_W-1:0] SSP_INIT = '0,
    parameter logic [SP_W-1:0] USP_INIT = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_super,
    input  logic            wr_en,
    input  logic [SP_W-1:0] wr_data,
    output logic [SP_W-1:0] sp_active
);

    localparam int N_BANK = 2;

    logic [SP_W-1:0] bank_q [N_BANK];

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        localparam logic [SP_W-1:0] INIT = (b == 1) ? SSP_INIT : USP_INIT;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_q[b] <= INIT;
            end else if (wr_en && (sel_super == (b == 1))) begin
                bank_q[b] <= wr_data;
            end
        end
    end

    assign sp_active = sel_super ? bank_q[1] : bank_q[0];

    p_other_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_super) |=> ($stable(bank_q[0]) && bank_q[1] == $past(wr_data)));

    p_other_kept_user_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel_super) |=> ($stable(bank_q[1]) && bank_q[0] == $past(wr_data)));

endmodule

// File: rtl/psr_irq_gate.sv
module psr_irq_gate #(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] mask,
    output logic             fwd
);

    localparam logic [LVL_W-1:0] LVL_TOP = '1;

    assign fwd = (level > mask) || (level == LVL_TOP);

    p_zero_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |-> !fwd);

    p_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == LVL_TOP && level != LVL_TOP) |-> !fwd);

endmodule

// File: rtl/psr_unit.sv
module psr_unit
    import psr_pkg::*;
#(
    parameter int SP_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alu_flag_we,
    input  logic [FLAG_W-1:0] alu_flags,
    input  logic              sr_wr_en,
    input  logic              sr_wr_full,
    input  logic [SR_W-1:0]   sr_wr_data,
    input  logic              exc_req,
    input  logic              sp_wr_en,
    input  logic [SP_W-1:0]   sp_wr_data,
    input  logic [MASK_W-1:0] irq_level,
    output logic [SR_W-1:0]   sr_out,
    output logic [SR_W-1:0]   saved_sr,
    output logic              supv_mode,
    output logic              trace_en,
    output logic [MASK_W-1:0] int_mask,
    output logic              priv_viol,
    output logic [SP_W-1:0]   sp_out,
    output logic              irq_fwd
);

    logic              supv_w;
    logic              trace_w;
    logic [MASK_W-1:0] mask_w;
    logic [FLAG_W-1:0] flags_w;
    logic [SR_W-1:0]   saved_q;

    psr_mode_fsm u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .exc_req  (exc_req),
        .wr_en    (sr_wr_en),
        .wr_full  (sr_wr_full),
        .wr_trace (sr_wr_data[BIT_TR]),
        .wr_super (sr_wr_data[BIT_SV]),
        .wr_mask  (sr_wr_data[MASK_HI:MASK_LO]),
        .supv     (supv_w),
        .trace    (trace_w),
        .mask     (mask_w),
        .viol     (priv_viol)
    );

    psr_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .exc_req   (exc_req),
        .supv      (supv_w),
        .wr_en     (sr_wr_en),
        .wr_full   (sr_wr_full),
        .wr_flags  (sr_wr_data[FLAG_W-1:0]),
        .alu_we    (alu_flag_we),
        .alu_flags (alu_flags),
        .flags     (flags_w)
    );

    psr_sp_bank #(.SP_W(SP_W)) u_sp (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_super (supv_w),
        .wr_en     (sp_wr_en),
        .wr_data   (sp_wr_data),
        .sp_active (sp_out)
    );

    psr_irq_gate #(.LVL_W(MASK_W)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .level (irq_level),
        .mask  (mask_w),
        .fwd   (irq_fwd)
    );

    assign sr_out    = pack_sr(trace_w, supv_w, mask_w, flags_w);
    assign supv_mode = supv_w;
    assign trace_en  = trace_w;
    assign int_mask  = mask_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            saved_q <= '0;
        end else if (exc_req) begin
            saved_q <= sr_out;
        end
    end

    assign saved_sr = saved_q;

    p_exc_saves_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> (saved_sr == $past(sr_out)));

    p_viol_no_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
        priv_viol |-> (sr_out == $past(sr_out)));

endmodule

// File: tb/tb_psr_unit.sv
module tb_psr_unit;
    import psr_pkg::*;

    localparam int SP_W = 32;
    localparam int NV   = 10;
    // vector: alu_we | alu_flags[5] | wr_en | wr_full | wr_data[16] | exc | exp_sr[16] | exp_viol
    localparam logic [41:0] VEC [NV] = '{
        {1'b1, 5'h15, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h2715, 1'b0}, // R2
        {1'b1, 5'h1F, 1'b1, 1'b0, 16'hFFEA, 1'b0, 16'h270A, 1'b0}, // R3 write beats ALU
        {1'b0, 5'h00, 1'b1, 1'b1, 16'hFFFF, 1'b0, 16'hA71F, 1'b0}, // R4 reserved zero
        {1'b0, 5'h00, 1'b1, 1'b1, 16'h0503, 1'b0, 16'h0503, 1'b0}, // R4 drop to user
        {1'b0, 5'h00, 1'b1, 1'b1, 16'h2700, 1'b0, 16'h0503, 1'b1}, // R5 refused
        {1'b0, 5'h00, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0503, 1'b0}, // R5 one cycle
        {1'b0, 5'h00, 1'b1, 1'b0, 16'h001C, 1'b0, 16'h051C, 1'b0}, // R3 user low byte
        {1'b1, 5'h0F, 1'b1, 1'b1, 16'hFFFF, 1'b1, 16'h251C, 1'b0}, // R6 priority
        {1'b0, 5'h00, 1'b1, 1'b1, 16'h8200, 1'b0, 16'h8200, 1'b0}, // R4 trace on
        {1'b0, 5'h00, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h2200, 1'b0}  // R6 trace cleared
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alu_flag_we = 1'b0;
    logic [FLAG_W-1:0] alu_flags = '0;
    logic              sr_wr_en = 1'b0;
    logic              sr_wr_full = 1'b0;
    logic [SR_W-1:0]   sr_wr_data = '0;
    logic              exc_req = 1'b0;
    logic              sp_wr_en = 1'b0;
    logic [SP_W-1:0]   sp_wr_data = '0;
    logic [MASK_W-1:0] irq_level = '0;
    logic [SR_W-1:0]   sr_out;
    logic [SR_W-1:0]   saved_sr;
    logic              supv_mode;
    logic              trace_en;
    logic [MASK_W-1:0] int_mask;
    logic              priv_viol;
    logic [SP_W-1:0]   sp_out;
    logic              irq_fwd;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    psr_unit #(.SP_W(SP_W)) dut (
        .clk(clk), .rst_n(rst_n), .alu_flag_we(alu_flag_we), .alu_flags(alu_flags),
        .sr_wr_en(sr_wr_en), .sr_wr_full(sr_wr_full), .sr_wr_data(sr_wr_data),
        .exc_req(exc_req), .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data),
        .irq_level(irq_level), .sr_out(sr_out), .saved_sr(saved_sr),
        .supv_mode(supv_mode), .trace_en(trace_en), .int_mask(int_mask),
        .priv_viol(priv_viol), .sp_out(sp_out), .irq_fwd(irq_fwd)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        alu_flag_we = 1'b0;
        sr_wr_en    = 1'b0;
        sr_wr_full  = 1'b0;
        exc_req     = 1'b0;
        sp_wr_en    = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic full_wr(input logic [15:0] d);
        idle();
        sr_wr_en = 1'b1; sr_wr_full = 1'b1; sr_wr_data = d;
        tick();
        idle();
    endtask

    task automatic fields_r10();
        chk("R10", "supv_mode", 32'(supv_mode), 32'(sr_out[13]));
        chk("R10", "trace_en",  32'(trace_en),  32'(sr_out[15]));
        chk("R10", "int_mask",  32'(int_mask),  32'(sr_out[10:8]));
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "sr_out", 32'(sr_out), 32'h2700);
        chk("R1", "supv_mode", 32'(supv_mode), 32'd1);
        chk("R1", "int_mask", 32'(int_mask), 32'd7);
        chk("R1", "trace_en", 32'(trace_en), 32'd0);
        chk("R1", "priv_viol", 32'(priv_viol), 32'd0);
        chk("R1", "sp_out", sp_out, 32'd0);

        for (int i = 0; i < NV; i++) begin
            alu_flag_we = VEC[i][41];
            alu_flags   = VEC[i][40:36];
            sr_wr_en    = VEC[i][35];
            sr_wr_full  = VEC[i][34];
            sr_wr_data  = VEC[i][33:18];
            exc_req     = VEC[i][17];
            tick();
            chk("R2-5/R6 vec", $sformatf("sr_out[%0d]", i), 32'(sr_out), 32'(VEC[i][16:1]));
            chk("R5", $sformatf("priv_viol[%0d]", i), 32'(priv_viol), 32'(VEC[i][0]));
            fields_r10();
        end
        idle();

        // R8 / R7 stack banks (now supervisor, sr 0x2200)
        sp_wr_en = 1'b1; sp_wr_data = 32'h0000_1000;
        tick(); idle();
        chk("R8", "ssp write", sp_out, 32'h0000_1000);
        full_wr(16'h0000);
        chk("R7", "user copy shown", sp_out, 32'h0);
        chk("R7", "sr user", 32'(sr_out), 32'h0000);
        sp_wr_en = 1'b1; sp_wr_data = 32'h0000_2000;
        tick(); idle();
        chk("R8", "usp write", sp_out, 32'h0000_2000);
        exc_req = 1'b1;
        tick(); idle();
        chk("R7", "super copy after exception", sp_out, 32'h0000_1000);
        chk("R6", "saved_sr", 32'(saved_sr), 32'h0000);
        chk("R6", "sr after entry", 32'(sr_out), 32'h2000);
        full_wr(16'h8004);
        chk("R8", "usp kept", sp_out, 32'h0000_2000);
        chk("R4", "trace user word", 32'(sr_out), 32'h8004);
        exc_req = 1'b1;
        tick(); idle();
        chk("R6", "saved_sr traced", 32'(saved_sr), 32'h8004);
        chk("R6", "sr entry clears trace", 32'(sr_out), 32'h2004);
        fields_r10();

        // R9 interrupt gate
        full_wr(16'h2300);
        chk("R9", "mask 3", 32'(int_mask), 32'd3);
        irq_level = 3'd3; #1;
        chk("R9", "level 3 vs mask 3", 32'(irq_fwd), 32'd0);
        irq_level = 3'd4; #1;
        chk("R9", "level 4 vs mask 3", 32'(irq_fwd), 32'd1);
        irq_level = 3'd0; #1;
        chk("R9", "level 0", 32'(irq_fwd), 32'd0);
        full_wr(16'h2700);
        irq_level = 3'd7; #1;
        chk("R9", "level 7 vs mask 7", 32'(irq_fwd), 32'd1);
        irq_level = 3'd6; #1;
        chk("R9", "level 6 vs mask 7", 32'(irq_fwd), 32'd0);
        irq_level = 3'd0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule